// File: doc/BRIEF.md
# Cascaded Lowest-Index Interrupt Controller

This block takes fifteen external interrupt request lines and delivers them one at a time to a processor over a single interrupt output. Inside it are two identical eight-line controller units. The second unit's output feeds input 2 of the first unit, so the fifteen lines share one output, one vector port and one acknowledge port. Each unit detects rising edges on its synchronized inputs and keeps one pending bit per line. When it is idle, it takes the lowest-numbered line that is pending and not masked. It latches the vector `base + line` and raises its output. It then waits until the processor writes the acknowledge offset.

Software programs a mask and a vector base for each unit through a small register port. Address bit 2 chooses the unit, and the two low address bits choose the register. Masking a line holds back its delivery but never discards the request. When the first unit is serving input 2, reading its vector returns the second unit's vector, and its acknowledge also releases the second unit.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset, `int_o` is low, both masks read 0, the first-unit base reads 0x20, the second-unit base reads 0x28, and the vector offset reads 0.
- R2: Among lines that are pending and unmasked, the lowest index is served first. The second unit's group ranks at position 2 of the first unit, below first-unit lines 0 and 1 and above lines 3 to 7.
- R3: The vector of a served line is `base + line` modulo 256. It is latched no later than the cycle in which `int_o` rises, and it stays unchanged while `int_o` is high.
- R4: `int_o` stays high until a write to offset 1 (address 1). It is low in the cycle after that write, and the unit then scans again.
- R5: A rising edge on a masked line (mask bit = 1) is kept pending and is delivered after the mask bit is cleared.
- R6: Writing offset 3 sets the vector base, and reading it returns the written value. A base near 0xFF wraps the vector.
- R7: External lines 8..15 enter the second unit. Its output drives input 2 of the first unit. A vector read at address 0 while the first unit's served line is 2 returns the second unit's vector, and an acknowledge at address 1 then also releases the second unit.
- R8: `irq_i[2]` has no effect.
- R9: An acknowledge written while nothing is in service changes nothing: later requests are served normally.
- R10: A request that arrives while another line is in service stays pending and is served after the acknowledge.
- R11: Register map: `reg_addr[2]` = 0 selects the first unit and 1 the second. Offset 0 reads the vector, offset 1 is acknowledge (it reads 0), offset 2 is the mask, and offset 3 is the base. Read data appears on the clock edge that takes the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Request lines; bits 0..7 go to the first unit (bit 2 unused), bits 8..15 to the second |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Unit select (bit 2) and offset (bits 1:0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| int_o | output | 1 | Interrupt to the processor |

## Verification
The assertions assume that each request stays high for at least as many cycles as the synchronizer has stages. They also assume that acknowledges go to the first unit, so that the two units stay in step. The bench holds every pulse for three cycles and sends all acknowledges to address 1.

The ordering checks need the competing requests to be pending at the same moment. The second unit's output reaches the first unit several cycles after an external edge. For this reason the bench masks every line, sends the pulses, unmasks the second unit, waits, and only then unmasks the first unit.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [1:0] {
    OFF_VEC  = 2'd0,
    OFF_ACK  = 2'd1,
    OFF_MASK = 2'd2,
    OFF_BASE = 2'd3
  } reg_off_e;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int unsigned LINES       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] pend_o
);
  logic [LINES-1:0] chain_in [SYNC_STAGES];
  logic [LINES-1:0] stage_q  [SYNC_STAGES];
  logic [LINES-1:0] last_q;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] pend_d, pend_q;

  assign chain_in[0] = req_i;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s > 0) begin : g_link
      assign chain_in[s] = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= chain_in[s];
    end
  end

  assign rise = stage_q[SYNC_STAGES-1] & ~last_q;

  always_comb begin
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      pend_q <= '0;
    end else begin
      last_q <= stage_q[SYNC_STAGES-1];
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] elig_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
  parameter int unsigned     LINES       = 8,
  parameter int unsigned     VEC_W       = 8,
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] RESET_BASE = 'h20,
  localparam int unsigned    IDX_W       = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic             ack_i,
  input  logic             mask_we_i,
  input  logic             base_we_i,
  input  logic [VEC_W-1:0] wdata_i,
  output logic             int_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] line_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [LINES-1:0] mask_o,
  output logic [VEC_W-1:0] base_o,
  output logic [LINES-1:0] elig_o
);
  logic [LINES-1:0] pend, clr, elig;
  logic             found;
  logic [IDX_W-1:0] pick;

  logic             busy_d, busy_q;
  logic [IDX_W-1:0] line_d, line_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic [LINES-1:0] mask_d, mask_q;
  logic [VEC_W-1:0] base_d, base_q;
  logic             svc_en, cfg_en;

  irq_edge_capture #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign elig = pend & ~mask_q;

  irq_pick_lowest #(.LINES(LINES)) u_pick (
    .elig_i  (elig),
    .found_o (found),
    .idx_o   (pick)
  );

  always_comb begin
    busy_d = busy_q;
    line_d = line_q;
    vec_d  = vec_q;
    mask_d = mask_q;
    base_d = base_q;
    clr    = '0;
    if (ack_i && busy_q) begin
      busy_d      = 1'b0;
      clr[line_q] = 1'b1;
    end else if (!busy_q && found) begin
      busy_d = 1'b1;
      line_d = pick;
      vec_d  = base_q + VEC_W'(pick);
    end
    if (mask_we_i) mask_d = LINES'(wdata_i);
    if (base_we_i) base_d = wdata_i;
  end

  assign svc_en = (ack_i && busy_q) || (!busy_q && found);
  assign cfg_en = mask_we_i || base_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      line_q <= '0;
      vec_q  <= '0;
    end else if (svc_en) begin
      busy_q <= busy_d;
      line_q <= line_d;
      vec_q  <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= RESET_BASE;
    end else if (cfg_en) begin
      mask_q <= mask_d;
      base_q <= base_d;
    end
  end

  assign int_o  = busy_q;
  assign busy_o = busy_q;
  assign line_o = line_q;
  assign vec_o  = vec_q;
  assign mask_o = mask_q;
  assign base_o = base_q;
  assign elig_o = elig;
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irq_cascade_pkg::*;
#(
  parameter int unsigned      LINES        = 8,
  parameter int unsigned      VEC_W        = 8,
  parameter int unsigned      SYNC_STAGES  = 2,
  parameter int unsigned      CASCADE_LINE = 2,
  parameter logic [VEC_W-1:0] MASTER_BASE  = 'h20,
  parameter logic [VEC_W-1:0] SLAVE_BASE   = 'h28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*LINES-1:0]    irq_i,
  input  logic                  reg_valid,
  input  logic                  reg_write,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [VEC_W-1:0]      reg_wdata,
  output logic [VEC_W-1:0]      reg_rdata,
  output logic                  int_o
);
  localparam int unsigned      IDX_W   = $clog2(LINES);
  localparam logic [IDX_W-1:0] CAS_IDX = IDX_W'(CASCADE_LINE);

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic     wr, rd, sel_s;
  reg_off_e off;
  assign wr    = reg_valid && reg_write;
  assign rd    = reg_valid && !reg_write;
  assign sel_s = reg_addr[2];
  assign off   = reg_off_e'(reg_addr[1:0]);

  logic             m_int, m_busy, s_int, s_busy;
  logic [IDX_W-1:0] m_line, s_line;
  logic [VEC_W-1:0] m_vec, s_vec, m_base, s_base;
  logic [LINES-1:0] m_mask, s_mask, m_elig, s_elig, m_req, s_req;
  logic             m_ack, s_ack;
  logic             unused_cascade_pin;

  assign unused_cascade_pin = irq_i[CASCADE_LINE];

  always_comb begin
    m_req               = irq_i[LINES-1:0];
    m_req[CASCADE_LINE] = s_int;
  end
  assign s_req = irq_i[2*LINES-1:LINES];

  assign m_ack = wr && !sel_s && (off == OFF_ACK);
  assign s_ack = (wr && sel_s && (off == OFF_ACK))
              || (m_ack && m_busy && (m_line == CAS_IDX));

  irq_unit #(.LINES(LINES), .VEC_W(VEC_W), .SYNC_STAGES(SYNC_STAGES),
             .RESET_BASE(SLAVE_BASE)) u_slave (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_i     (s_req),
    .ack_i     (s_ack),
    .mask_we_i (wr && sel_s && (off == OFF_MASK)),
    .base_we_i (wr && sel_s && (off == OFF_BASE)),
    .wdata_i   (reg_wdata),
    .int_o     (s_int),
    .busy_o    (s_busy),
    .line_o    (s_line),
    .vec_o     (s_vec),
    .mask_o    (s_mask),
    .base_o    (s_base),
    .elig_o    (s_elig)
  );

  irq_unit #(.LINES(LINES), .VEC_W(VEC_W), .SYNC_STAGES(SYNC_STAGES),
             .RESET_BASE(MASTER_BASE)) u_master (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_i     (m_req),
    .ack_i     (m_ack),
    .mask_we_i (wr && !sel_s && (off == OFF_MASK)),
    .base_we_i (wr && !sel_s && (off == OFF_BASE)),
    .wdata_i   (reg_wdata),
    .int_o     (m_int),
    .busy_o    (m_busy),
    .line_o    (m_line),
    .vec_o     (m_vec),
    .mask_o    (m_mask),
    .base_o    (m_base),
    .elig_o    (m_elig)
  );

  logic [VEC_W-1:0] rd_d, rd_q;
  always_comb begin
    rd_d = '0;
    unique case (off)
      OFF_VEC:  rd_d = sel_s ? s_vec : ((m_line == CAS_IDX) ? s_vec : m_vec);
      OFF_MASK: rd_d = sel_s ? VEC_W'(s_mask) : VEC_W'(m_mask);
      OFF_BASE: rd_d = sel_s ? s_base : m_base;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_q <= '0;
    else if (rd) rd_q <= rd_d;
  end

  assign reg_rdata = rd_q;
  assign int_o     = m_int;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int unsigned LINES        = 8,
  parameter int unsigned VEC_W        = 8,
  parameter int unsigned CASCADE_LINE = 2,
  localparam int unsigned IDX_W       = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_i,
  input logic             reg_valid,
  input logic             reg_write,
  input logic [2:0]       reg_addr,
  input logic             int_o,
  input logic             m_busy,
  input logic [IDX_W-1:0] m_line,
  input logic [VEC_W-1:0] m_vec,
  input logic [VEC_W-1:0] m_base,
  input logic [LINES-1:0] m_mask,
  input logic [LINES-1:0] m_elig,
  input logic             s_busy,
  input logic [IDX_W-1:0] s_line,
  input logic [LINES-1:0] s_elig
);
  logic             ack_m;
  logic [LINES-1:0] below_m, below_s;
  assign ack_m   = reg_valid && reg_write && (reg_addr == 3'd1);
  assign below_m = ~({LINES{1'b1}} << m_line);
  assign below_s = ~({LINES{1'b1}} << s_line);

  assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(m_busy) |-> (($past(m_elig) & below_m) == '0));

  assert_slave_lowest_R2: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(s_busy) |-> (($past(s_elig) & below_s) == '0));

  assert_vec_formula_R3: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(m_busy) |-> (m_vec == VEC_W'($past(m_base) + VEC_W'(m_line))));

  assert_vec_stable_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (int_o && $past(int_o)) |-> $stable(m_vec));

  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (int_o && !ack_m) |=> int_o);

  assert_ack_drops_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (ack_m && int_o) |=> !int_o);

  assert_unmasked_pick_R5: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(m_busy) |-> (($past(m_mask) & (LINES'(1) << m_line)) == '0));

  assert_slave_release_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (ack_m && m_busy && (m_line == IDX_W'(CASCADE_LINE))) |=> !s_busy);
endmodule

bind irq_cascade_top irq_cascade_chk #(
  .LINES(LINES), .VEC_W(VEC_W), .CASCADE_LINE(CASCADE_LINE)
) u_chk (
  .clk       (clk),
  .rst_i     (rst_sync_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .int_o     (int_o),
  .m_busy    (m_busy),
  .m_line    (m_line),
  .m_vec     (m_vec),
  .m_base    (m_base),
  .m_mask    (m_mask),
  .m_elig    (m_elig),
  .s_busy    (s_busy),
  .s_line    (s_line),
  .s_elig    (s_elig)
);

// File: tb/sim_irq_cascade_top.sv
module sim_irq_cascade_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq;
  logic        reg_valid, reg_write;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        int_o;

  int total = 0;
  int bad   = 0;
  int mbase = 32'h20;
  int sbase = 32'h28;

  always #2 clk = ~clk;

  irq_cascade_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_i     (irq),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .int_o     (int_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input int addr, input int data);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1;
    reg_addr  = 3'(addr); reg_wdata = 8'(data);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input int addr, output int data);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 3'(addr);
    @(negedge clk);
    reg_valid = 1'b0;
    data = int'(reg_rdata);
  endtask

  task automatic pulse(input logic [15:0] lines);
    @(negedge clk);
    irq = lines;
    repeat (3) @(negedge clk);
    irq = '0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  function automatic int exp_vec(input int e);
    if (e < 8) return (mbase + e) & 32'hFF;
    return (sbase + e - 8) & 32'hFF;
  endfunction

  // Rank: first-unit line m -> 16*m, second-unit line s -> 32+s (slot of input 2)
  function automatic int rank(input int e);
    if (e < 8) return 16 * e;
    return 32 + e - 8;
  endfunction

  task automatic serve_expect(input string tag, input int e);
    int v;
    check({tag, " int high"}, int'(int_o), 1);
    reg_rd(0, v);
    check(tag, v, exp_vec(e));
    reg_wr(1, 0);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; irq = '0; reg_valid = 1'b0; reg_write = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 int low", int'(int_o), 0);
    reg_rd(0, v); check("R1 vector", v, 0);
    reg_rd(2, v); check("R1 mask m", v, 0);
    reg_rd(6, v); check("R1 mask s", v, 0);
    reg_rd(3, v); check("R1 base m", v, 32'h20);
    reg_rd(7, v); check("R1 base s", v, 32'h28);
    reg_rd(1, v); check("R11 ack reads zero", v, 0);

    // R9 ack while idle
    reg_wr(1, 0);
    settle();
    check("R9 idle ack int", int'(int_o), 0);

    // R8 unused pin
    pulse(16'h0004);
    settle();
    check("R8 pin2 ignored", int'(int_o), 0);

    // R3 R7 single-line sweep over all 15 lines
    for (int e = 0; e < 16; e++) begin
      if (e == 2) continue;
      pulse(16'(1) << e);
      settle();
      serve_expect($sformatf("R3 R7 single line %0d", e), e);
      check($sformatf("R4 line %0d released", e), int'(int_o), 0);
    end

    // R2 R5 all pairs, made simultaneous by mask staging
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        int first, second;
        if (a == 2 || b == 2) continue;
        reg_wr(2, 32'hFF);
        reg_wr(6, 32'hFF);
        pulse((16'(1) << a) | (16'(1) << b));
        settle();
        check("R5 masked held off", int'(int_o), 0);
        reg_wr(6, 0);
        settle();
        reg_wr(2, 0);
        settle();
        first  = (rank(a) < rank(b)) ? a : b;
        second = (first == a) ? b : a;
        serve_expect($sformatf("R2 pair %0d,%0d first", a, b), first);
        serve_expect($sformatf("R2 pair %0d,%0d second", a, b), second);
        check("R4 pair drained", int'(int_o), 0);
      end
    end

    // R4 hold until ack
    pulse(16'h0010);
    settle();
    repeat (40) @(negedge clk);
    check("R4 held", int'(int_o), 1);
    reg_rd(0, v); check("R3 vector stable", v, exp_vec(4));

    // R10 arrival during service
    pulse(16'h0001);
    settle();
    check("R10 still line 4", int'(int_o), 1);
    reg_rd(0, v); check("R10 vector unchanged", v, exp_vec(4));
    reg_wr(1, 0);
    settle();
    serve_expect("R10 late line 0", 0);

    // R5 R11 second-unit mask readback and delivery after unmask
    reg_wr(6, 32'h10);
    reg_rd(6, v); check("R11 slave mask readback", v, 32'h10);
    pulse(16'h1000);
    settle();
    check("R5 slave masked", int'(int_o), 0);
    reg_wr(6, 0);
    settle();
    serve_expect("R5 slave unmasked", 12);

    // R6 bases, including wrap
    reg_wr(3, 32'h60); mbase = 32'h60;
    reg_rd(3, v); check("R6 base m readback", v, 32'h60);
    pulse(16'h0080);
    settle();
    serve_expect("R6 new base m", 7);
    reg_wr(7, 32'hFC); sbase = 32'hFC;
    reg_rd(7, v); check("R6 base s readback", v, 32'hFC);
    pulse(16'h8000);
    settle();
    serve_expect("R6 wrap", 15);
    check("R6 wrap value", exp_vec(15), 32'h03);
    reg_rd(4, v); check("R11 slave vector offset", v, 32'h03);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule